// File: doc/BRIEF.md
# DDR Write-Turnaround Timing Guard

This block sits beside a DDR SDRAM command scheduler. Each cycle the scheduler presents one candidate command (write, read, precharge or activate) with its bank, burst-length code and auto-precharge flag. The guard answers in the same cycle with two things. The first is whether the bank may take the command at all. The second is whether issuing it now leaves every write burst in flight intact. A command that is legal but early still goes out, and the block marks it as truncating. A truncate pulse tells the write-data launcher how many data pairs of the cut burst count as written.

Write bursts deliver one data pair per clock, starting the cycle after the write command. A single tracker for the shared data bus times reads against the most recent write. Each bank keeps its own tracker for write recovery, plus one blocking counter. That counter covers the precharge period after an explicit precharge, and the whole closing period of a write with auto-precharge. All timing values are parameters in clock cycles.

The command port follows valid/ready rules. `cmd_ready` depends only on the addressed bank's state, never on `cmd_valid`. A command takes effect only in a cycle where both are high. The scheduler may change or withdraw a refused command at any time, and it does not have to hold it.

Top module: `ddr_wtg_guard`

## Requirements
- R1: During and right after reset, every bank is ready, every command is reported clean and `trunc_pulse` is low.
- R2: A write is always ready unless its bank is blocked. If it is accepted fewer cycles after the previous accepted write than that write's pair count, it truncates, and `trunc_pairs` equals the cycle distance between the two writes.
- R3: A read is clean when no write is tracked on the shared bus, or when at least (pairs + T_WTR) cycles have passed since the last accepted write, whatever the bank.
- R4: An earlier read is still ready but truncates, with `trunc_pairs` = max(distance − T_WTR, 0). Any accepted read ends tracking of the bus write.
- R5: A precharge is clean when its bank has no tracked write, or when at least (pairs + T_WR) cycles have passed since that bank's last write. Otherwise it truncates with `trunc_pairs` = max(distance − T_WR, 0).
- R6: After a precharge is accepted at cycle c, every command to that bank is refused until cycle c + T_RP, when it becomes ready again.
- R7: A write accepted at cycle t with `cmd_ap` high blocks its bank from cycle t+1 until cycle t + pairs + T_WR + T_RP. This is the same timing as an explicit precharge issued at the earliest clean cycle.
- R8: Burst code `cmd_bl` 0 gives 1 data pair (burst of 2), 1 gives 2 pairs (burst of 4), and 2 or 3 give 4 pairs (burst of 8). Pair k of a write accepted at cycle t lands in cycle t+1+k.
- R9: `trunc_pulse` is high only when `cmd_valid` and `cmd_ready` are high and the command is not clean. An activate is never reported as truncating.
- R10: A refused command changes no state. A refused write does not restart the bus write tracker, and a refused precharge does not extend blocking.

Command code `cmd_type`: 0 write, 1 read, 2 precharge, 3 activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_type | input | 2 | 0 write, 1 read, 2 precharge, 3 activate |
| cmd_bank | input | clog2(NB) | Target bank |
| cmd_bl | input | 2 | Burst-length code of a write (R8) |
| cmd_ap | input | 1 | Write with auto-precharge |
| cmd_ready | output | 1 | Addressed bank can take a command this cycle |
| cmd_clean | output | 1 | Issuing now leaves all bursts intact |
| trunc_pulse | output | 1 | Accepted command cuts a write burst short |
| trunc_pairs | output | 3 | Number of pairs of the cut burst that count as written |

## Verification
`cmd_ready`, `cmd_clean`, `trunc_pulse` and `trunc_pairs` are combinational on the presented command and its bank. They are due in the same cycle as the stimulus. The state change from an accepted command shows up from the next cycle onward. The bench drives inputs at the falling edge and compares all four outputs 1 ns later against a timestamp model. It then advances the model on the following rising edge, so a write accepted at cycle t is seen at distance 1 in cycle t+1. Directed sequences place reads, precharges and activates at exact distances from writes and precharges, and a long random run follows.

// File: rtl/ddr_wtg_pkg.sv
`timescale 1ns/1ps
package ddr_wtg_pkg;
  typedef enum logic [1:0] {
    CMD_WR  = 2'd0,
    CMD_RD  = 2'd1,
    CMD_PRE = 2'd2,
    CMD_ACT = 2'd3
  } cmd_e;

  // burst-length code to number of data pairs (R8)
  function automatic logic [2:0] bl_pairs(input logic [1:0] code);
    case (code)
      2'd0:    bl_pairs = 3'd1;
      2'd1:    bl_pairs = 3'd2;
      default: bl_pairs = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ddr_wtg_burst_track.sv
`timescale 1ns/1ps
module ddr_wtg_burst_track #(
  parameter int SAT = 12,
  parameter int SW  = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2:0]    load_pairs,
  input  logic          clear,
  output logic          seen,
  output logic [SW-1:0] since,
  output logic [2:0]    pairs
);
  // cycles since the last loaded write, saturating at SAT
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      since <= '0;
      pairs <= '0;
    end else if (load) begin
      seen  <= 1'b1;
      since <= SW'(1);
      pairs <= load_pairs;
    end else begin
      if (clear) seen <= 1'b0;
      if (seen && since != SW'(SAT)) since <= since + SW'(1);
    end
  end
endmodule

// File: rtl/ddr_wtg_bank.sv
`timescale 1ns/1ps
module ddr_wtg_bank #(
  parameter int T_WR = 3,
  parameter int T_RP = 3,
  parameter int SAT  = 12,
  parameter int SW   = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic          wr_ap,
  input  logic [2:0]    wr_pairs,
  input  logic          pre_hit,
  output logic          busy,
  output logic          seen,
  output logic [SW-1:0] since,
  output logic [2:0]    pairs
);
  localparam int BLK_MAX = 4 + T_WR + T_RP;
  localparam int BKW     = $clog2(BLK_MAX + 1);

  logic [BKW-1:0] blk;

  ddr_wtg_burst_track #(.SAT(SAT), .SW(SW)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .load(wr_hit), .load_pairs(wr_pairs), .clear(pre_hit),
    .seen(seen), .since(since), .pairs(pairs)
  );

  // one blocking counter: precharge period, or auto-precharge close-out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      blk <= '0;
    else if (pre_hit)
      blk <= BKW'(T_RP - 1);
    else if (wr_hit && wr_ap)
      blk <= BKW'(wr_pairs) + BKW'(T_WR + T_RP - 1);
    else if (blk != '0)
      blk <= blk - BKW'(1);
  end

  assign busy = (blk != '0);
endmodule

// File: rtl/ddr_wtg_guard.sv
`timescale 1ns/1ps
module ddr_wtg_guard
  import ddr_wtg_pkg::*;
#(
  parameter int NB    = 4,
  parameter int T_WTR = 2,
  parameter int T_WR  = 3,
  parameter int T_RP  = 3,
  parameter int BA_W  = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_type,
  input  logic [BA_W-1:0] cmd_bank,
  input  logic [1:0]      cmd_bl,
  input  logic            cmd_ap,
  output logic            cmd_ready,
  output logic            cmd_clean,
  output logic            trunc_pulse,
  output logic [2:0]      trunc_pairs
);
  localparam int SAT = 4 + T_WR + T_WTR + 1;
  localparam int SW  = $clog2(SAT + 1);

  cmd_e          ctype;
  logic          acc;
  logic [2:0]    new_pairs;
  logic          g_seen;
  logic [SW-1:0] g_since;
  logic [2:0]    g_pairs;
  logic          b_busy  [NB];
  logic          b_seen  [NB];
  logic [SW-1:0] b_since [NB];
  logic [2:0]    b_pairs [NB];
  logic          clean_c;
  int            n_c;

  assign ctype     = cmd_e'(cmd_type);
  assign new_pairs = bl_pairs(cmd_bl);
  assign cmd_ready = !b_busy[cmd_bank];
  assign acc       = cmd_valid && cmd_ready;

  // shared data bus: last write in any bank
  ddr_wtg_burst_track #(.SAT(SAT), .SW(SW)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .load(acc && ctype == CMD_WR), .load_pairs(new_pairs),
    .clear(acc && ctype == CMD_RD),
    .seen(g_seen), .since(g_since), .pairs(g_pairs)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    ddr_wtg_bank #(.T_WR(T_WR), .T_RP(T_RP), .SAT(SAT), .SW(SW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(acc && ctype == CMD_WR && cmd_bank == BA_W'(g)),
      .wr_ap(cmd_ap), .wr_pairs(new_pairs),
      .pre_hit(acc && ctype == CMD_PRE && cmd_bank == BA_W'(g)),
      .busy(b_busy[g]), .seen(b_seen[g]),
      .since(b_since[g]), .pairs(b_pairs[g])
    );
  end

  // classify the presented command as clean or truncating
  always_comb begin
    int s, p;
    clean_c = 1'b1;
    n_c     = 0;
    s       = 0;
    p       = 0;
    case (ctype)
      CMD_WR: begin
        s = int'(g_since);
        p = int'(g_pairs);
        if (g_seen && s < p) begin
          clean_c = 1'b0;
          n_c     = s;
        end
      end
      CMD_RD: begin
        s = int'(g_since);
        p = int'(g_pairs);
        if (g_seen && s < p + T_WTR) begin
          clean_c = 1'b0;
          n_c     = (s > T_WTR) ? s - T_WTR : 0;
        end
      end
      CMD_PRE: begin
        s = int'(b_since[cmd_bank]);
        p = int'(b_pairs[cmd_bank]);
        if (b_seen[cmd_bank] && s < p + T_WR) begin
          clean_c = 1'b0;
          n_c     = (s > T_WR) ? s - T_WR : 0;
        end
      end
      default: ;
    endcase
  end

  assign cmd_clean   = clean_c;
  assign trunc_pulse = acc && !clean_c;
  assign trunc_pairs = 3'(n_c);
endmodule

// File: rtl/ddr_wtg_chk.sv
`timescale 1ns/1ps
module ddr_wtg_chk #(
  parameter int NB    = 4,
  parameter int T_WTR = 2,
  parameter int T_WR  = 3,
  parameter int T_RP  = 3,
  parameter int BA_W  = $clog2(NB)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_type,
  input logic [BA_W-1:0] cmd_bank,
  input logic [1:0]      cmd_bl,
  input logic            cmd_ap,
  input logic            cmd_ready,
  input logic            cmd_clean,
  input logic            trunc_pulse,
  input logic [2:0]      trunc_pairs
);
  logic acc_c;
  assign acc_c = cmd_valid && cmd_ready;

  // R9: pulse only on an accepted non-activate command
  p_trunc_accepted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_pulse |-> (cmd_valid && cmd_ready && cmd_type != 2'd3));

  // R2: write in the cycle after a multi-pair write keeps exactly one pair
  p_wr_wr_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && cmd_type == 2'd0 && cmd_bl != 2'd0) |=>
      (!(cmd_valid && cmd_ready && cmd_type == 2'd0) || (trunc_pulse && trunc_pairs == 3'd1)));

  // R4: read right after a write keeps no pairs
  if (T_WTR >= 1) begin : g_r4
    p_wr_rd_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_c && cmd_type == 2'd0) |=>
        (!(cmd_valid && cmd_ready && cmd_type == 2'd1) || (trunc_pulse && trunc_pairs == 3'd0)));
  end

  // R6: bank refuses in the cycle after its precharge
  if (T_RP > 1) begin : g_r6
    p_pre_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_c && cmd_type == 2'd2) |=> (cmd_bank != $past(cmd_bank) || !cmd_ready));
  end

  // R7: auto-precharge write closes its bank at once
  p_ap_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && cmd_type == 2'd0 && cmd_ap) |=> (cmd_bank != $past(cmd_bank) || !cmd_ready));

  // R9: a clean command never pulses
  p_clean_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clean |-> !trunc_pulse);
endmodule

bind ddr_wtg_guard ddr_wtg_chk #(
  .NB(NB), .T_WTR(T_WTR), .T_WR(T_WR), .T_RP(T_RP), .BA_W(BA_W)
) u_chk (.*);

// File: tb/sim_ddr_wtg_guard.sv
`timescale 1ns/1ps
module sim_ddr_wtg_guard;
  localparam int NB = 4, T_WTR = 2, T_WR = 3, T_RP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic [1:0] cmd_bl = 2'd0;
  logic cmd_ap = 1'b0;
  logic cmd_ready, cmd_clean, trunc_pulse;
  logic [2:0] trunc_pairs;

  int tests = 0, fails = 0;
  int cyc = 0;
  bit gw_on = 0;
  int gw_t = 0, gw_p = 0;
  bit bw_on [NB];
  int bw_t [NB], bw_p [NB], bfree [NB];

  always #2.5 clk = ~clk;

  ddr_wtg_guard #(.NB(NB), .T_WTR(T_WTR), .T_WR(T_WR), .T_RP(T_RP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cmd_bl(cmd_bl), .cmd_ap(cmd_ap),
    .cmd_ready(cmd_ready), .cmd_clean(cmd_clean),
    .trunc_pulse(trunc_pulse), .trunc_pairs(trunc_pairs)
  );

  function automatic int pairs_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  // one clock: drive at falling edge, compare, then advance model at rising edge
  task automatic step(input bit v, input int t, input int b, input int bl, input bit ap,
                      input string tag);
    bit e_rdy, e_cln, e_tr;
    int e_n, d;
    @(negedge clk);
    cmd_valid = v; cmd_type = 2'(t); cmd_bank = 2'(b); cmd_bl = 2'(bl); cmd_ap = ap;
    #1;
    e_rdy = (cyc >= bfree[b]);
    e_cln = 1; e_n = 0;
    case (t)
      0: begin d = cyc - gw_t;
        if (gw_on && d < gw_p) begin e_cln = 0; e_n = d; end end
      1: begin d = cyc - gw_t;
        if (gw_on && d < gw_p + T_WTR) begin e_cln = 0; e_n = (d > T_WTR) ? d - T_WTR : 0; end end
      2: begin d = cyc - bw_t[b];
        if (bw_on[b] && d < bw_p[b] + T_WR) begin e_cln = 0; e_n = (d > T_WR) ? d - T_WR : 0; end end
      default: ;
    endcase
    e_tr = v && e_rdy && !e_cln;
    chk(tag, "ready", int'(cmd_ready), int'(e_rdy));
    chk(tag, "clean", int'(cmd_clean), int'(e_cln));
    chk(tag, "trunc_pulse", int'(trunc_pulse), int'(e_tr));
    if (e_tr) chk(tag, "trunc_pairs", int'(trunc_pairs), e_n);
    @(posedge clk);
    if (v && e_rdy) begin
      case (t)
        0: begin
          gw_on = 1; gw_t = cyc; gw_p = pairs_of(2'(bl));
          bw_on[b] = 1; bw_t[b] = cyc; bw_p[b] = pairs_of(2'(bl));
          if (ap) bfree[b] = cyc + pairs_of(2'(bl)) + T_WR + T_RP;
        end
        1: gw_on = 0;
        2: begin bw_on[b] = 0; bfree[b] = cyc + T_RP; end
        default: ;
      endcase
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 3, 0, 0, 0, "idle");
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin bw_on[i] = 0; bw_t[i] = 0; bw_p[i] = 0; bfree[i] = 0; end
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmd_valid = 1; cmd_type = 2'd2; cmd_bank = 2'd1; #1;
    chk("R1", "ready in reset", int'(cmd_ready), 1);
    chk("R1", "clean in reset", int'(cmd_clean), 1);
    chk("R1", "pulse in reset", int'(trunc_pulse), 0);
    cmd_valid = 0;
    @(negedge clk); rst_n = 1;
    step(1, 1, 0, 0, 0, "R1");
    // R2 / R8: write cut by write one cycle later
    step(1, 0, 0, 1, 0, "R8");
    step(1, 0, 1, 2, 0, "R2");
    idle(10);
    // R4: read right after write
    step(1, 0, 0, 1, 0, "R4");
    step(1, 1, 2, 0, 0, "R4");
    idle(4);
    // R3: read late after BL2 write
    step(1, 0, 2, 0, 0, "R8");
    idle(2);
    step(1, 1, 0, 0, 0, "R3");
    // R4: BL8 write, read at distance 4 keeps 2 pairs
    step(1, 0, 3, 2, 0, "R8");
    idle(3);
    step(1, 1, 1, 0, 0, "R4");
    idle(8);
    // R5 / R6: early precharge, then bank blocked
    step(1, 0, 1, 1, 0, "R5");
    step(1, 2, 1, 0, 0, "R5");
    step(1, 3, 1, 0, 0, "R6");
    step(1, 3, 1, 0, 0, "R6");
    step(1, 3, 1, 0, 0, "R6");
    idle(4);
    // R5: late precharge is clean
    step(1, 0, 2, 1, 0, "R5");
    idle(4);
    step(1, 2, 2, 0, 0, "R5");
    idle(4);
    // R7: auto-precharge write
    step(1, 0, 3, 1, 1, "R7");
    for (int i = 0; i < 8; i++) step(1, 1, 3, 0, 0, "R7");
    step(1, 3, 3, 0, 0, "R7");
    idle(10);
    // R10: refused write leaves the bus tracker alone
    step(1, 2, 2, 0, 0, "R10");
    step(1, 0, 2, 2, 0, "R10");
    step(1, 1, 0, 0, 0, "R10");
    step(1, 2, 2, 0, 0, "R10");
    idle(4);
    // R9: activate right after a write
    step(1, 0, 0, 2, 0, "R9");
    step(1, 3, 0, 0, 0, "R9");
    idle(8);
    // random traffic
    for (int i = 0; i < 5000; i++) begin
      int t;
      t = int'($urandom_range(0, 3));
      step($urandom_range(0, 9) < 6, t, int'($urandom_range(0, NB - 1)),
           int'($urandom_range(0, 3)), $urandom_range(0, 4) == 0,
           t == 0 ? "R2" : t == 1 ? "R4" : t == 2 ? "R5" : "R9");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule